// File: doc/BRIEF.md
# Snoop Response Combiner

On a snooping bus, every cache checks its tags against each transaction and reports back. This block collects those per-cache reports for one transaction. It reduces them to the shared and dirty bus signals, raises a valid strobe once the result may be sampled, and decides who supplies the data. Either main memory supplies it, or one selected cache does. A requester on a read miss installs the line exclusive when the shared result is low and shared when it is high. Memory stays off the data bus whenever a modified copy exists.

A transaction opens when `addr_valid` is sampled while the block is idle. Each cache then raises its ready line once, together with its hit and modified bits. Two completion policies are available at build time. In the waiting policy (`FIXED_LAT = 0`), the result is published only after every cache has reported. In the deadline policy (`FIXED_LAT = 1`), the result is published a fixed `LATENCY` clocks after the address, and any cache still silent at that point is flagged. `CLEAN_FWD` chooses whether a clean sharer, rather than memory, supplies unmodified data.

Top module: `snoop_resp_agg`

## Requirements
- R1: While reset is active, and on the first cycle after it, every output is 0.
- R2: With FIXED_LAT=0, snoop_valid is high for exactly one cycle. That cycle follows the clock edge at which the last cache's first ready is sampled. snoop_valid stays low until every cache has reported.
- R3: With FIXED_LAT=1, snoop_valid is high for the one cycle after the LATENCY-th edge following the edge that accepted addr_valid. late_err is high in that cycle exactly when some cache had not reported by that edge, and a silent cache contributes no hit and no modified bit. With FIXED_LAT=0, late_err is always 0.
- R4: bus_shared is the OR of the hit bits of all caches that reported in the transaction.
- R5: bus_dirty is the OR of the modified bits of all caches that reported in the transaction.
- R6: When snoop_valid is high, mem_respond is high exactly when bus_dirty is low, and also (with CLEAN_FWD=1) bus_shared is low. Exactly one of mem_respond and sup_valid is high.
- R7: When bus_dirty is high, sup_valid is 1 and sup_idx is the lowest cache index that reported modified. Otherwise, with CLEAN_FWD=1 and bus_shared high, sup_idx is the lowest index that reported a hit. When sup_valid is 0, sup_idx is 0.
- R8: Whenever snoop_valid is low, bus_shared, bus_dirty, mem_respond, sup_valid, late_err and sup_idx are all 0.
- R9: addr_valid has no effect while a transaction is open. Ready, hit and modified inputs have no effect while the block is idle.
- R10: Only a cache's first ready in a transaction is recorded, with the hit and modified bits of that cycle. Hit and modified bits given while that cache's ready is low are ignored. A report is kept after ready drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_valid | input | 1 | Address of a new bus transaction is on the bus |
| snp_rdy | input | N_CACHES | Per-cache snoop report is present this cycle |
| snp_hit | input | N_CACHES | Per-cache: holds a copy of the line |
| snp_dirty | input | N_CACHES | Per-cache: holds a modified copy of the line |
| snoop_valid | output | 1 | Snoop result may be sampled this cycle |
| bus_shared | output | 1 | Some cache holds a copy |
| bus_dirty | output | 1 | Some cache holds a modified copy |
| mem_respond | output | 1 | Memory must supply the data |
| sup_valid | output | 1 | A cache supplies the data |
| sup_idx | output | max(1,clog2(N_CACHES)) | Index of the supplying cache |
| late_err | output | 1 | A cache missed the fixed deadline |

## Verification
The bench drives two copies with the same stimulus, both with four caches. The first uses the waiting policy with clean-sharer forwarding. The second uses a four-clock deadline with memory supplying all clean data. Report delays run from one to six clocks, so the deadline copy sees both on-time and late caches. The waiting copy sees completions from one to six clocks. A second address strobe arrives during an open transaction. All-ones noise is given between transactions, and hit and modified lines toggle while ready is low. Together these reach every supplier choice, the priority among several modified or sharing caches, and both ignore rules.

// File: rtl/snp_pkg.sv
package snp_pkg;

   typedef enum logic {
      PH_IDLE   = 1'b0,
      PH_GATHER = 1'b1
   } snp_phase_e;

   typedef struct packed {
      logic shared;
      logic dirty;
      logic mem;
      logic sup;
      logic late;
   } snp_flags_t;

endpackage

// File: rtl/snp_collect.sv
module snp_collect #(
   parameter int N_CACHES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                enable,
   input  logic [N_CACHES-1:0] rdy,
   input  logic [N_CACHES-1:0] hit,
   input  logic [N_CACHES-1:0] dirty,
   output logic [N_CACHES-1:0] rdy_m,
   output logic [N_CACHES-1:0] hit_m,
   output logic [N_CACHES-1:0] dty_m
);

   // One slot per cache: keeps the first report of the open transaction
   // and merges a report arriving on the current edge.
   for (genvar i = 0; i < N_CACHES; i++) begin : g_slot
      logic seen_q, hit_q, dty_q;
      logic take;

      assign take = enable && rdy[i] && !seen_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen_q <= 1'b0;
            hit_q  <= 1'b0;
            dty_q  <= 1'b0;
         end else if (clear) begin
            seen_q <= 1'b0;
            hit_q  <= 1'b0;
            dty_q  <= 1'b0;
         end else if (take) begin
            seen_q <= 1'b1;
            hit_q  <= hit[i];
            dty_q  <= dirty[i];
         end
      end

      assign rdy_m[i] = seen_q || take;
      assign hit_m[i] = seen_q ? hit_q : (take && hit[i]);
      assign dty_m[i] = seen_q ? dty_q : (take && dirty[i]);
   end

endmodule

// File: rtl/snp_timer.sv
module snp_timer
   import snp_pkg::*;
#(
   parameter bit FIXED_LAT = 1'b0,
   parameter int LATENCY   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic addr_valid,
   input  logic all_rdy,
   output logic start,
   output logic busy,
   output logic done,
   output logic late
);

   localparam int CW = $clog2(LATENCY + 1);

   snp_phase_e ph_q;

   assign busy  = (ph_q == PH_GATHER);
   assign start = addr_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ph_q <= PH_IDLE;
      else if (start) ph_q <= PH_GATHER;
      else if (done)  ph_q <= PH_IDLE;
   end

   if (FIXED_LAT) begin : g_fixed
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (start)          cnt_q <= CW'(1);
         else if (busy && !done)  cnt_q <= cnt_q + 1'b1;
      end

      assign done = busy && (cnt_q == CW'(LATENCY));
      assign late = done && !all_rdy;
   end else begin : g_wait
      assign done = busy && all_rdy;
      assign late = 1'b0;
   end

endmodule

// File: rtl/snp_resolve.sv
module snp_resolve
   import snp_pkg::*;
#(
   parameter int N_CACHES  = 4,
   parameter bit CLEAN_FWD = 1'b0
) (
   input  logic [N_CACHES-1:0] hit,
   input  logic [N_CACHES-1:0] dirty,
   input  logic                late,
   output snp_flags_t          flags,
   output logic [((N_CACHES > 1) ? $clog2(N_CACHES) : 1)-1:0] idx
);

   localparam int IW = (N_CACHES > 1) ? $clog2(N_CACHES) : 1;

   logic          any_hit, any_dty;
   logic [IW-1:0] d_idx;

   assign any_hit = |hit;
   assign any_dty = |dirty;

   // lowest-index modified copy wins
   always_comb begin
      d_idx = '0;
      for (int i = N_CACHES - 1; i >= 0; i--)
         if (dirty[i]) d_idx = IW'(i);
   end

   assign flags.shared = any_hit;
   assign flags.dirty  = any_dty;
   assign flags.late   = late;

   if (CLEAN_FWD) begin : g_fwd
      logic [IW-1:0] h_idx;

      always_comb begin
         h_idx = '0;
         for (int i = N_CACHES - 1; i >= 0; i--)
            if (hit[i]) h_idx = IW'(i);
      end

      assign flags.mem = !any_dty && !any_hit;
      assign flags.sup = any_dty || any_hit;
      assign idx       = any_dty ? d_idx : (any_hit ? h_idx : '0);
   end else begin : g_mem
      assign flags.mem = !any_dty;
      assign flags.sup = any_dty;
      assign idx       = any_dty ? d_idx : '0;
   end

endmodule

// File: rtl/snoop_resp_agg.sv
module snoop_resp_agg
   import snp_pkg::*;
#(
   parameter int N_CACHES  = 4,
   parameter bit FIXED_LAT = 1'b0,
   parameter int LATENCY   = 4,
   parameter bit CLEAN_FWD = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                addr_valid,
   input  logic [N_CACHES-1:0] snp_rdy,
   input  logic [N_CACHES-1:0] snp_hit,
   input  logic [N_CACHES-1:0] snp_dirty,
   output logic                snoop_valid,
   output logic                bus_shared,
   output logic                bus_dirty,
   output logic                mem_respond,
   output logic                sup_valid,
   output logic [((N_CACHES > 1) ? $clog2(N_CACHES) : 1)-1:0] sup_idx,
   output logic                late_err
);

   localparam int IW = (N_CACHES > 1) ? $clog2(N_CACHES) : 1;

   if (N_CACHES < 1 || N_CACHES > 64) begin : g_bad_count
      $error("snoop_resp_agg: N_CACHES must lie in 1..64");
   end
   if (LATENCY < 1) begin : g_bad_latency
      $error("snoop_resp_agg: LATENCY must be at least 1");
   end

   logic                start, busy, done, late;
   logic [N_CACHES-1:0] rdy_m, hit_m, dty_m;
   snp_flags_t          fl;
   snp_flags_t          fl_q;
   logic [IW-1:0]       idx;
   logic [IW-1:0]       idx_q;
   logic                valid_q;

   snp_timer #(
      .FIXED_LAT (FIXED_LAT),
      .LATENCY   (LATENCY)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_valid (addr_valid),
      .all_rdy    (&rdy_m),
      .start      (start),
      .busy       (busy),
      .done       (done),
      .late       (late)
   );

   snp_collect #(
      .N_CACHES (N_CACHES)
   ) u_collect (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .enable (busy),
      .rdy    (snp_rdy),
      .hit    (snp_hit),
      .dirty  (snp_dirty),
      .rdy_m  (rdy_m),
      .hit_m  (hit_m),
      .dty_m  (dty_m)
   );

   snp_resolve #(
      .N_CACHES  (N_CACHES),
      .CLEAN_FWD (CLEAN_FWD)
   ) u_resolve (
      .hit   (hit_m),
      .dirty (dty_m),
      .late  (late),
      .flags (fl),
      .idx   (idx)
   );

   // Result register: all outputs are held at zero outside the valid cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         fl_q    <= '0;
         idx_q   <= '0;
      end else if (done) begin
         valid_q <= 1'b1;
         fl_q    <= fl;
         idx_q   <= idx;
      end else begin
         valid_q <= 1'b0;
         fl_q    <= '0;
         idx_q   <= '0;
      end
   end

   assign snoop_valid = valid_q;
   assign bus_shared  = fl_q.shared;
   assign bus_dirty   = fl_q.dirty;
   assign mem_respond = fl_q.mem;
   assign sup_valid   = fl_q.sup;
   assign late_err    = fl_q.late;
   assign sup_idx     = idx_q;

endmodule

// File: rtl/snoop_resp_agg_chk.sv
module snoop_resp_agg_chk #(
   parameter int N_CACHES  = 4,
   parameter bit FIXED_LAT = 1'b0,
   parameter int LATENCY   = 4
) (
   input logic clk,
   input logic rst_n,
   input logic addr_valid,
   input logic snoop_valid,
   input logic bus_shared,
   input logic bus_dirty,
   input logic mem_respond,
   input logic sup_valid,
   input logic [((N_CACHES > 1) ? $clog2(N_CACHES) : 1)-1:0] sup_idx,
   input logic late_err
);

   localparam int CW = $clog2(LATENCY + 1);

   // R8
   quiet_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snoop_valid |-> !(bus_shared || bus_dirty || mem_respond || sup_valid || late_err)
                       && (sup_idx == '0));

   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid |=> !snoop_valid);

   // R6
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid |-> (mem_respond != sup_valid));

   // R6
   dirty_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dirty |-> !mem_respond);

   // R7
   dirty_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dirty |-> sup_valid);

   // R7
   idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sup_valid |-> (int'(sup_idx) < N_CACHES));

   if (FIXED_LAT) begin : g_deadline
      logic          open_q;
      logic [CW-1:0] age_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q <= 1'b0;
            age_q  <= '0;
         end else if (!open_q) begin
            if (addr_valid) begin
               open_q <= 1'b1;
               age_q  <= CW'(1);
            end
         end else if (age_q == CW'(LATENCY)) begin
            open_q <= 1'b0;
         end else begin
            age_q <= age_q + 1'b1;
         end
      end

      // R3
      deadline_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (open_q && age_q == CW'(LATENCY)) |=> snoop_valid);

      // R3
      no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         snoop_valid |-> $past(open_q && age_q == CW'(LATENCY)));
   end else begin : g_waiting
      // R3
      no_late_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !late_err);
   end

endmodule

bind snoop_resp_agg snoop_resp_agg_chk #(
   .N_CACHES  (N_CACHES),
   .FIXED_LAT (FIXED_LAT),
   .LATENCY   (LATENCY)
) u_chk (.*);

// File: tb/test_snoop_resp_agg.sv
`timescale 1ns/1ps

module test_ref #(
   parameter int N   = 4,
   parameter bit FIX = 1'b0,
   parameter int LAT = 4,
   parameter bit FWD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         addr,
   input  logic [N-1:0] rdy,
   input  logic [N-1:0] hit,
   input  logic [N-1:0] dirty,
   output bit           e_valid,
   output bit           e_shared,
   output bit           e_dirty,
   output bit           e_mem,
   output bit           e_sup,
   output int           e_idx,
   output bit           e_late
);
   bit open;
   int age;
   bit got[N];
   bit gh[N];
   bit gd[N];

   always @(posedge clk) begin
      e_valid = 0; e_shared = 0; e_dirty = 0; e_mem = 0;
      e_sup = 0; e_idx = 0; e_late = 0;
      if (!rst_n) begin
         open = 0; age = 0;
      end else if (!open) begin
         if (addr) begin
            open = 1; age = 1;
            foreach (got[i]) begin got[i] = 0; gh[i] = 0; gd[i] = 0; end
         end
      end else begin
         bit all;
         int dfirst, hfirst;
         all = 1;
         foreach (got[i]) begin
            if (rdy[i] && !got[i]) begin
               got[i] = 1; gh[i] = hit[i]; gd[i] = dirty[i];
            end
            if (!got[i]) all = 0;
         end
         if (FIX ? (age == LAT) : all) begin
            open = 0;
            e_valid = 1;
            dfirst = -1; hfirst = -1;
            for (int i = 0; i < N; i++) begin
               if (gd[i]) begin e_dirty = 1; if (dfirst < 0) dfirst = i; end
               if (gh[i]) begin e_shared = 1; if (hfirst < 0) hfirst = i; end
            end
            if (e_dirty) begin
               e_sup = 1; e_idx = dfirst;
            end else if (FWD && e_shared) begin
               e_sup = 1; e_idx = hfirst;
            end else begin
               e_mem = 1;
            end
            e_late = FIX && !all;
         end else begin
            age++;
         end
      end
   end
endmodule

module test_snoop_resp_agg;
   localparam int N   = 4;
   localparam int LAT = 4;

   logic         clk = 0;
   logic         rst_n = 0;
   logic         addr_valid = 0;
   logic [N-1:0] snp_rdy = '0, snp_hit = '0, snp_dirty = '0;

   logic       v_valid, v_shared, v_dirty, v_mem, v_sup, v_late;
   logic [1:0] v_idx;
   logic       f_valid, f_shared, f_dirty, f_mem, f_sup, f_late;
   logic [1:0] f_idx;

   bit ev_v, es_v, ed_v, em_v, eu_v, el_v; int ei_v;
   bit ev_f, es_f, ed_f, em_f, eu_f, el_f; int ei_f;

   int nchk = 0, nerr = 0;
   bit done_run = 0;

   always #5 clk = ~clk;

   snoop_resp_agg #(.N_CACHES(N), .FIXED_LAT(1'b0), .LATENCY(LAT), .CLEAN_FWD(1'b1)) i_snoop_resp_agg (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
      .snp_rdy(snp_rdy), .snp_hit(snp_hit), .snp_dirty(snp_dirty),
      .snoop_valid(v_valid), .bus_shared(v_shared), .bus_dirty(v_dirty),
      .mem_respond(v_mem), .sup_valid(v_sup), .sup_idx(v_idx), .late_err(v_late));

   snoop_resp_agg #(.N_CACHES(N), .FIXED_LAT(1'b1), .LATENCY(LAT), .CLEAN_FWD(1'b0)) i_snoop_resp_agg_fix (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
      .snp_rdy(snp_rdy), .snp_hit(snp_hit), .snp_dirty(snp_dirty),
      .snoop_valid(f_valid), .bus_shared(f_shared), .bus_dirty(f_dirty),
      .mem_respond(f_mem), .sup_valid(f_sup), .sup_idx(f_idx), .late_err(f_late));

   test_ref #(.N(N), .FIX(1'b0), .LAT(LAT), .FWD(1'b1)) u_ref_v (
      .clk(clk), .rst_n(rst_n), .addr(addr_valid), .rdy(snp_rdy), .hit(snp_hit), .dirty(snp_dirty),
      .e_valid(ev_v), .e_shared(es_v), .e_dirty(ed_v), .e_mem(em_v), .e_sup(eu_v), .e_idx(ei_v), .e_late(el_v));

   test_ref #(.N(N), .FIX(1'b1), .LAT(LAT), .FWD(1'b0)) u_ref_f (
      .clk(clk), .rst_n(rst_n), .addr(addr_valid), .rdy(snp_rdy), .hit(snp_hit), .dirty(snp_dirty),
      .e_valid(ev_f), .e_shared(es_f), .e_dirty(ed_f), .e_mem(em_f), .e_sup(eu_f), .e_idx(ei_f), .e_late(el_f));

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the reference models
   always @(negedge clk) begin
      if (rst_n && !done_run) begin
         check("R2 R9 valid (wait)", int'(v_valid), int'(ev_v));
         check(ev_v ? "R4 R10 shared (wait)" : "R8 shared (wait)", int'(v_shared), int'(es_v));
         check(ev_v ? "R5 dirty (wait)" : "R8 dirty (wait)", int'(v_dirty), int'(ed_v));
         check(ev_v ? "R6 mem (wait)" : "R8 mem (wait)", int'(v_mem), int'(em_v));
         check(ev_v ? "R7 sup (wait)" : "R8 sup (wait)", int'(v_sup), int'(eu_v));
         check("R7 sup_idx (wait)", int'(v_idx), ei_v);
         check("R3 late (wait)", int'(v_late), int'(el_v));
         check("R3 R9 valid (deadline)", int'(f_valid), int'(ev_f));
         check(ev_f ? "R4 R10 shared (deadline)" : "R8 shared (deadline)", int'(f_shared), int'(es_f));
         check(ev_f ? "R5 dirty (deadline)" : "R8 dirty (deadline)", int'(f_dirty), int'(ed_f));
         check(ev_f ? "R6 mem (deadline)" : "R8 mem (deadline)", int'(f_mem), int'(em_f));
         check(ev_f ? "R7 sup (deadline)" : "R8 sup (deadline)", int'(f_sup), int'(eu_f));
         check("R7 sup_idx (deadline)", int'(f_idx), ei_f);
         check("R3 late (deadline)", int'(f_late), int'(el_f));
      end
   end

   // One transaction: cache i reports once, dl[i] edges after the address.
   // Hit/modified lines carry inverted values while ready is low (R10).
   task automatic txn(input logic [N-1:0] h, input logic [N-1:0] d,
                      input int d0, input int d1, input int d2, input int d3,
                      input bit extra);
      int dl[N];
      dl[0] = d0; dl[1] = d1; dl[2] = d2; dl[3] = d3;
      @(negedge clk);
      addr_valid = 1; snp_rdy = '0; snp_hit = '0; snp_dirty = '0;
      for (int t = 1; t <= 7; t++) begin
         @(negedge clk);
         addr_valid = extra && (t == 2);   // R9: strobe during an open transaction
         for (int i = 0; i < N; i++) snp_rdy[i] = (dl[i] == t);
         snp_hit   = (snp_rdy & h) | (~snp_rdy & ~h);
         snp_dirty = (snp_rdy & d) | (~snp_rdy & ~d);
      end
      @(negedge clk);
      addr_valid = 0; snp_rdy = '0; snp_hit = '0; snp_dirty = '0;
      @(negedge clk);
      // R9: idle-time noise
      snp_rdy = '1; snp_hit = '1; snp_dirty = '1;
      @(negedge clk);
      snp_rdy = '0; snp_hit = '0; snp_dirty = '0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done_run) begin
         nerr++; nchk++;
         $display("FAIL watchdog expired");
         done_run = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      // R1: outputs low in reset
      check("R1 reset valid", int'(v_valid | f_valid), 0);
      check("R1 reset flags", int'(v_shared | v_dirty | v_mem | v_sup | v_late |
                                   f_shared | f_dirty | f_mem | f_sup | f_late), 0);
      check("R1 reset idx", int'(v_idx) + int'(f_idx), 0);
      rst_n = 1;
      @(negedge clk);
      check("R1 post-reset valid", int'(v_valid | f_valid), 0);

      txn(4'b0000, 4'b0000, 1, 2, 3, 4, 0);   // R6: memory supplies
      txn(4'b0110, 4'b0000, 2, 1, 3, 1, 0);   // R4 R7: lowest sharer 1
      txn(4'b1100, 4'b1100, 1, 1, 1, 1, 1);   // R5 R7: lowest dirty 2, R9 extra strobe
      txn(4'b0010, 4'b0010, 1, 6, 2, 3, 0);   // R3: cache 1 misses deadline
      txn(4'b1111, 4'b1010, 4, 4, 4, 4, 1);   // R3: all exactly on deadline
      txn(4'b1001, 4'b0000, 5, 5, 5, 5, 0);   // R3: everyone late

      lf = 16'hACE1;
      for (int n = 0; n < 40; n++) begin
         int a, b, c, e;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         a = 1 + (int'(lf[10:8]) % 6);
         b = 1 + (int'(lf[13:11]) % 6);
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         c = 1 + (int'(lf[10:8]) % 6);
         e = 1 + (int'(lf[13:11]) % 6);
         txn(lf[3:0], lf[7:4] & lf[3:0], a, b, c, e, lf[15]);
      end

      repeat (4) @(negedge clk);
      done_run = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule